// File: doc/BRIEF.md
# DRAM Open-Page Hit Detector with Row-Time Timing Latch

This block sits in front of an external DRAM sequencer. For every external access request it decides whether the access may continue in the currently open page as a column-only cycle, or must begin with a fresh row-address cycle. It keeps the page part of the last accepted address. It compares each new address against that stored page, using a compare mask that a 4-bit page-size code selects at run time. The page-size encoding is not monotonic, and one code turns page mode off altogether.

On each access that becomes a row cycle, the block also captures a 3-bit memory-timing code. That code selects one of eight timing families and stays in force for every following column access until the next row cycle. Each decision is registered and appears one clock after the request, with a valid strobe.

A small state machine tracks whether any page is open. It has two states. `PG_NONE` means no page is open, and it is the reset state. `PG_OPEN` means a stored page is valid. The transition `T_OPEN` moves from `PG_NONE` to `PG_OPEN` on the first accepted request. The transition `T_STAY` keeps `PG_OPEN` on every later cycle. Reset returns the machine to `PG_NONE`.

Top module: `dram_page_detect`

## Requirements
- R1: While reset is held and on the first cycle after it, `dec_valid` is 0 and `timing_mode` is 3'b111 (three cycles per column).
- R2: Every cycle with `req_valid` high yields `dec_valid` high on the next cycle. A cycle without a request yields `dec_valid` low on the next cycle. Every request is accepted.
- R3: The first request after reset always gives `dec_row` = 1 (row cycle), whatever its address.
- R4: When every compared address bit equals the corresponding bit of the last accepted address, `dec_row` = 0 (column cycle). If any compared bit differs, `dec_row` = 1.
- R5: Page codes 4'b0000, 4'b0001, 4'b0010, 4'b0011 and 4'b0100 compare address bits [31:6], [31:7], [31:8], [31:9] and [31:10] respectively.
- R6: Page codes 4'b1001 to 4'b1111 compare bits [31:11] to [31:17], in steps of one bit. Codes 4'b0101, 4'b0110 and 4'b0111 compare [31:18], [31:19] and [31:20].
- R7: Page code 4'b1000 disables page mode, so every request under it gives `dec_row` = 1.
- R8: On a row decision, `timing_mode` takes the `timing_code` presented with that request and shows it in the same cycle as `dec_valid`. Column decisions and idle cycles leave `timing_mode` unchanged. The encodings are as follows. 000 and 001 are single-beat SDRAM with CAS latency 2 and 3. 010 and 011 are two-beat interleaved SDRAM with CAS latency 2 and 3. 100 is pipelined, one cycle per column. 101 is non-pipelined, one cycle per column. 110 is two cycles per column. 111 is three cycles per column.
- R9: Every accepted request, whether row or column, replaces the stored page. Changing the page code between requests does not invalidate the stored page; the new mask applies from the next comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | External access request, always accepted |
| req_addr | input | 32 | Byte address of the request |
| page_code | input | 4 | Page-size selection code |
| timing_code | input | 3 | Memory timing code, used only on row cycles |
| dec_valid | output | 1 | Decision valid, one cycle after a request |
| dec_row | output | 1 | 1 = new row-address cycle, 0 = column cycle |
| timing_mode | output | 3 | Timing code latched at the latest row cycle |

## Verification
Several checks hold on every cycle. The assertions confirm the one-cycle strobe relation, that the first decision from `PG_NONE` is a row, that the page-off code forces rows, and that a repeated address while a page is open gives a column. They also confirm that `timing_mode` moves only with a row decision, and that the compare mask is always a contiguous run from bit 31 down.

Other behaviour only the bench's scenarios can show. These include the exact boundary bit for each of the sixteen page codes, where the bench flips the bit just below and just above the boundary. They also include the survival of the stored page across a page-code change, and the replacement of the stored page on column hits. The bench's randomized mix of codes and addresses is checked against an independent reference model.

// File: rtl/dpg_pkg.sv
package dpg_pkg;

    localparam int ADDR_W   = 32;
    localparam int PAGE_LSB = 6;
    localparam int PAGE_W   = ADDR_W - PAGE_LSB;
    localparam int CODE_W   = 4;
    localparam int TM_W     = 3;

    localparam logic [CODE_W-1:0] CODE_NOPAGE = 4'b1000;

    typedef enum logic [TM_W-1:0] {
        TM_SD_B1_CL2  = 3'b000,
        TM_SD_B1_CL3  = 3'b001,
        TM_SD_B2_CL2  = 3'b010,
        TM_SD_B2_CL3  = 3'b011,
        TM_PIPE_1C    = 3'b100,
        TM_NOPIPE_1C  = 3'b101,
        TM_TWO_C      = 3'b110,
        TM_THREE_C    = 3'b111
    } tmode_e;

    typedef enum logic {
        PG_NONE = 1'b0,
        PG_OPEN = 1'b1
    } pstate_e;

    // Lowest compared address bit for a page code (0 means page mode off).
    function automatic int page_low_bit(input logic [CODE_W-1:0] code);
        int low;
        if (code == CODE_NOPAGE)      low = 0;
        else if (code[3])             low = 10 + int'(code[2:0]);
        else if (code <= 4'b0100)     low = PAGE_LSB + int'(code);
        else                          low = 13 + int'(code);
        return low;
    endfunction

endpackage

// File: rtl/dpg_mask_dec.sv
module dpg_mask_dec
    import dpg_pkg::*;
#(
    parameter int A_W   = ADDR_W,
    parameter int P_LSB = PAGE_LSB,
    localparam int P_W  = A_W - P_LSB
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [P_W-1:0]    mask_o,
    output logic              off_o
);

    int low_bit;

    always_comb begin
        low_bit = page_low_bit(code_i);
        off_o   = (code_i == CODE_NOPAGE);
    end

    for (genvar gi = 0; gi < P_W; gi++) begin : g_mask
        assign mask_o[gi] = (gi + P_LSB) >= low_bit;
    end

    always_comb begin
        if (!off_o) begin
            AST_MASK_CONTIG: assert (mask_o[P_W-1] && (((~mask_o) & ((~mask_o) + 1'b1)) == '0))
                else $error("mask not contiguous from top"); // R5 R6
        end
    end

endmodule

// File: rtl/dpg_page_store.sv
module dpg_page_store
    import dpg_pkg::*;
#(
    parameter int P_W = PAGE_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  logic [P_W-1:0] page_i,
    input  logic [P_W-1:0] mask_i,
    output logic           hit_o
);

    logic [P_W-1:0] page_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      page_q <= '0;
        else if (load_i) page_q <= page_i;
    end

    assign hit_o = (((page_q ^ page_i) & mask_i) == '0);

endmodule

// File: rtl/dpg_timing_latch.sv
module dpg_timing_latch
    import dpg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [TM_W-1:0] code_i,
    output tmode_e          mode_o
);

    always_ff @(posedge clk) begin
        if (!rst_n)      mode_o <= TM_THREE_C;
        else if (load_i) mode_o <= tmode_e'(code_i);
    end

endmodule

// File: rtl/dram_page_detect.sv
module dram_page_detect
    import dpg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [CODE_W-1:0]   page_code,
    input  logic [TM_W-1:0]     timing_code,
    output logic                dec_valid,
    output logic                dec_row,
    output logic [TM_W-1:0]     timing_mode
);

    pstate_e          state_q, state_d;
    logic [PAGE_W-1:0] mask;
    logic             page_off;
    logic             page_hit;
    logic             row_now;
    tmode_e           mode_q;

    dpg_mask_dec #(.A_W(ADDR_W), .P_LSB(PAGE_LSB)) u_mask (
        .code_i (page_code),
        .mask_o (mask),
        .off_o  (page_off)
    );

    dpg_page_store #(.P_W(PAGE_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (req_valid),
        .page_i (req_addr[ADDR_W-1:PAGE_LSB]),
        .mask_i (mask),
        .hit_o  (page_hit)
    );

    // Next-state: T_OPEN from PG_NONE on a request, T_STAY in PG_OPEN.
    always_comb begin
        state_d = state_q;
        row_now = 1'b1;
        unique case (state_q)
            PG_NONE: begin
                row_now = 1'b1;
                if (req_valid) state_d = PG_OPEN;
            end
            PG_OPEN: begin
                row_now = page_off || !page_hit;
                state_d = PG_OPEN;
            end
            default: state_d = PG_NONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PG_NONE;
        else        state_q <= state_d;
    end

    dpg_timing_latch u_tm (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (req_valid && row_now),
        .code_i (timing_code),
        .mode_o (mode_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid <= 1'b0;
            dec_row   <= 1'b0;
        end else begin
            dec_valid <= req_valid;
            dec_row   <= req_valid && row_now;
        end
    end

    assign timing_mode = mode_q;

    AST_DEC_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> dec_valid) else $error("missing decision"); // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !dec_valid) else $error("spurious decision"); // R2
    AST_FIRST_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && state_q == PG_NONE) |=> dec_row) else $error("first access not row"); // R3
    AST_SAME_ADDR_COL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && $past(req_valid) && state_q == PG_OPEN && req_addr == $past(req_addr)
         && page_code != CODE_NOPAGE) |=> !dec_row) else $error("repeat address not column"); // R4
    AST_NOPAGE_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && page_code == CODE_NOPAGE) |=> dec_row) else $error("page-off not row"); // R7
    AST_TM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec_valid && dec_row) |-> $stable(timing_mode)) else $error("timing moved"); // R8
    AST_TM_SAMPLED: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_row) |-> timing_mode == $past(timing_code)) else $error("timing not latched"); // R8

endmodule

// File: tb/sim_dram_page_detect.sv
`timescale 1ns/1ps
module sim_dram_page_detect;

    typedef struct {
        logic       row;
        logic [2:0] tm;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [3:0]  page_code = '0;
    logic [2:0]  timing_code = '0;
    logic        dec_valid, dec_row;
    logic [2:0]  timing_mode;

    int checks = 0;
    int fails  = 0;
    exp_t        sbq[$];
    logic        m_valid = 1'b0;
    logic [31:0] m_addr  = '0;
    logic [2:0]  m_tm    = 3'b111;
    logic        in_reset = 1'b1;

    always #2.5 clk = ~clk;

    dram_page_detect u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .page_code(page_code), .timing_code(timing_code),
        .dec_valid(dec_valid), .dec_row(dec_row), .timing_mode(timing_mode)
    );

    function automatic int low_of(input logic [3:0] c);
        case (c)
            4'b0000: return 6;   4'b0001: return 7;   4'b0010: return 8;
            4'b0011: return 9;   4'b0100: return 10;  4'b0101: return 18;
            4'b0110: return 19;  4'b0111: return 20;  4'b1000: return -1;
            4'b1001: return 11;  4'b1010: return 12;  4'b1011: return 13;
            4'b1100: return 14;  4'b1101: return 15;  4'b1110: return 16;
            default: return 17;
        endcase
    endfunction

    task automatic check(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", what, act, exp);
        end
    endtask

    task automatic send(input logic [31:0] a, input logic [3:0] c, input logic [2:0] t, input string tag);
        exp_t e;
        int   lb;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; page_code = c; timing_code = t;
        lb = low_of(c);
        if (!m_valid || lb < 0) e.row = 1'b1;
        else e.row = ((m_addr >> lb) != (a >> lb));
        if (e.row) m_tm = t;
        e.tm = m_tm; e.tag = tag;
        m_valid = 1'b1; m_addr = a;
        sbq.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    // Monitor: compare each decision against the scoreboard head.
    always @(negedge clk) begin
        if (!in_reset && dec_valid) begin
            if (sbq.size() == 0) begin
                checks++; fails++;
                $display("FAIL R2: actual decision without request expected none");
            end else begin
                exp_t e;
                e = sbq.pop_front();
                check(dec_row, e.row, {e.tag, " row"});
                checks++;
                if (timing_mode !== e.tm) begin
                    fails++;
                    $display("FAIL %s R8 timing: actual %0d expected %0d", e.tag, timing_mode, e.tm);
                end
            end
        end
    end

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        repeat (3) @(negedge clk);
        check(dec_valid, 1'b0, "R1 dec_valid in reset");
        checks++; if (timing_mode !== 3'b111) begin fails++; $display("FAIL R1: timing actual %0d expected 7", timing_mode); end
        rst_n = 1'b1;
        @(negedge clk);
        in_reset = 1'b0;
        check(dec_valid, 1'b0, "R1 dec_valid after reset");

        send(32'h1000_0040, 4'b0000, 3'b010, "R3 first");
        send(32'h1000_007C, 4'b0000, 3'b101, "R4 hit R8 hold");
        send(32'h1000_0080, 4'b0000, 3'b101, "R4 miss");
        send(32'h1000_00C0, 4'b0001, 3'b001, "R9 code change");
        idle(2);
        check(dec_valid, 1'b0, "R2 idle no strobe");
        send(32'h1000_00C0, 4'b1000, 3'b100, "R7 off");
        send(32'h1000_00C0, 4'b1000, 3'b110, "R7 off repeat");

        // Boundary sweep over all page codes: R5 R6 R7.
        for (int c = 0; c < 16; c++) begin
            int lb;
            logic [31:0] b;
            lb = low_of(4'(c));
            b = 32'h2400_0000 + (32'(c) << 22);
            send(b, 4'(c), 3'(c), "R5 R6 base");
            if (lb > 0) begin
                send(b ^ (32'h1 << (lb - 1)), 4'(c), 3'(c + 1), "R5 R6 below");
                send(b ^ (32'h1 << lb), 4'(c), 3'(c + 2), "R5 R6 at");
            end else begin
                send(b ^ 32'h1, 4'(c), 3'(c + 1), "R7 small");
            end
        end
        idle(3);

        // Randomized mix: R4 R8 R9.
        lfsr = 32'hACE1_2345;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            send(32'h4000_0000 | (lfsr & 32'h001F_FFC0) | {26'h0, lfsr[29:24]},
                 lfsr[3:0], lfsr[6:4], "R4 R9 random");
            if (lfsr[10:8] == 3'b000) idle(1);
        end
        idle(3);

        // Reset mid-run: R1 R3.
        rst_n = 1'b0; in_reset = 1'b1;
        m_valid = 1'b0; m_tm = 3'b111;
        idle(2);
        check(dec_valid, 1'b0, "R1 mid reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        in_reset = 1'b0;
        checks++; if (timing_mode !== 3'b111) begin fails++; $display("FAIL R1: timing actual %0d expected 7", timing_mode); end
        send(32'h4000_0000, 4'b1111, 3'b011, "R3 after reset");
        send(32'h4000_0000, 4'b1111, 3'b000, "R4 R8 after reset hit");
        idle(4);
        checks++;
        if (sbq.size() != 0) begin fails++; $display("FAIL R2: actual %0d pending expected 0", sbq.size()); end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule